// File: doc/BRIEF.md
# Privilege Mode and Trap Entry Controller

This block owns the processor's privilege mode bit and steers every transfer of control into and out of exception handlers. The core reports instruction boundaries, the address of the instruction at the boundary, any synchronous fault it detected, attempts to run a privileged operation, and return-from-handler requests. I/O completion and hardware fault requests arrive from outside, and a built-in countdown timer adds a third external source. The timer can only be loaded from kernel mode, so the kernel can always get control back.

The hardware entry path is the only route into kernel mode. No instruction selects kernel mode. The core may only request a drop to user mode. On entry the block presents a vector-table address for the core's program counter, saves the interrupted address, records the cause, and turns external interrupts off until the handler returns. External requests that arrive while interrupts are off are latched and wait.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block is in kernel mode (`mode_o`=0; user mode is 1), interrupts are disabled, the timer count is 0, `pc_load_o` is low, and `cause_o` and `epc_o` are 0.
- R2: On an accepted entry, `pc_load_o` is high in the same cycle and `pc_next_o` = VEC_BASE + cause*VEC_STRIDE. After the next clock edge, `epc_o` holds `cur_pc_i` from the entry cycle and `cause_o` holds the cause code.
- R3: After an entry edge, mode is kernel and interrupts are disabled. Mode changes to kernel only through an entry or a return to a kernel context. `set_user_i` (with no entry or return) selects user mode and enables interrupts at the next edge.
- R4: `trap_i` bit k (overflow=0, divide-by-zero=1, illegal op=2, out-of-range reference=3, explicit trap=4) requests cause code k. These are taken at a boundary whatever the interrupt-enable state, and the lowest set bit wins.
- R5: `priv_op_i` in user mode at a boundary raises cause 5, unless a `trap_i` cause is also present. In kernel mode it raises nothing.
- R6: External causes are hardware fault=6, timer=7 and I/O=8, with priority in that order. They are taken only at a boundary while interrupts are enabled, and any synchronous cause beats all of them.
- R7: A one-cycle pulse on `io_irq_i` or `hw_fault_i` becomes pending at the next edge. It stays pending while interrupts are disabled, and it is cleared only when that cause is taken.
- R8: `eret_i` drives `pc_load_o` high in the same cycle with `pc_next_o` = `epc_o`. At the next edge the mode held before the last entry comes back and interrupts are enabled. `eret_i` suppresses an entry in the same cycle.
- R9: A timer load takes effect only in kernel mode. The count then drops by one per clock and stops at 0. Stepping from 1 to 0 makes the timer cause pending. Loading 0, and the reset value of 0, raise nothing.
- R10: Without `boundary_i`, no cause starts an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boundary_i | input | 1 | Core is at an instruction boundary |
| cur_pc_i | input | ADDR_W | Address of the instruction at the boundary |
| trap_i | input | 5 | Synchronous trap causes, bit k = cause k |
| priv_op_i | input | 1 | Current instruction is privileged |
| io_irq_i | input | 1 | I/O completion request pulse |
| hw_fault_i | input | 1 | Hardware fault request pulse |
| set_user_i | input | 1 | Drop to user mode |
| eret_i | input | 1 | Return from handler |
| tmr_load_i | input | 1 | Load the countdown timer |
| tmr_val_i | input | TMR_W | Timer load value |
| pc_load_o | output | 1 | Core must load `pc_next_o` |
| pc_next_o | output | ADDR_W | Vector or return address |
| epc_o | output | ADDR_W | Saved return address |
| cause_o | output | 4 | Cause of the last entry |
| mode_o | output | 1 | 0 kernel, 1 user |
| ie_o | output | 1 | External interrupts enabled |
| tmr_count_o | output | TMR_W | Current timer count |

## Verification
`pc_load_o` and `pc_next_o` are combinational. They are due in the same cycle as the boundary or return request, so the bench samples them 1 ns after driving, before the next rising edge. Mode, enable, saved address and cause are registered and due one edge later, so they are read at the following falling edge. A pulse on an external request becomes pending at the edge that ends the pulse and can be taken at the next boundary. After a kernel load of V, the timer reads V at the next falling edge and then one less at each following one. The sweeps walk through all synchronous trap masks with and without a privileged operation, and the bench computes the winning cause and vector address from the lowest set bit.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int NSYNC  = 5;
  localparam int NEXT   = 3;
  localparam int NCAUSE = NSYNC + 1 + NEXT;
  localparam int CW     = 4;

  typedef enum logic [CW-1:0] {
    CS_OVF  = 4'd0,
    CS_DIVZ = 4'd1,
    CS_ILL  = 4'd2,
    CS_MEMV = 4'd3,
    CS_SYSC = 4'd4,
    CS_PRIV = 4'd5,
    CS_HWF  = 4'd6,
    CS_TMR  = 4'd7,
    CS_IO   = 4'd8
  } cause_e;

  localparam logic MODE_KERNEL = 1'b0;
  localparam logic MODE_USER   = 1'b1;
endpackage

// File: rtl/priv_timer.sv
module priv_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  input  logic             user_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             ld_ok;

  assign ld_ok = load_i & ~user_i;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (ld_ok) begin
      cnt_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d    = cnt_q - TMR_W'(1);
      expire_o = (cnt_q == TMR_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: a user-mode load leaves a stopped timer stopped
  a_r9_user_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && user_i && cnt_q == '0) |=> (cnt_q == '0));
  // R9: with no load, the count never wraps past zero
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ok && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/priv_cause_sel.sv
module priv_cause_sel #(
  parameter int NREQ = 9,
  parameter int CW   = 4
) (
  input  logic [NREQ-1:0] req_i,
  output logic            hit_o,
  output logic [CW-1:0]   idx_o
);
  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CW'(i);
    end
  end
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int TMR_W      = 8,
  parameter int VEC_BASE   = 256,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [NSYNC-1:0]  trap_i,
  input  logic              priv_op_i,
  input  logic              io_irq_i,
  input  logic              hw_fault_i,
  input  logic              set_user_i,
  input  logic              eret_i,
  input  logic              tmr_load_i,
  input  logic [TMR_W-1:0]  tmr_val_i,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [CW-1:0]     cause_o,
  output logic              mode_o,
  output logic              ie_o,
  output logic [TMR_W-1:0]  tmr_count_o
);
  localparam int EXT_LO = NSYNC + 1;

  logic              mode_q, mode_d, prev_q, prev_d, ie_q, ie_d;
  logic [ADDR_W-1:0] epc_q, epc_d;
  logic [CW-1:0]     cause_q, cause_d;
  logic [NEXT-1:0]   pend_q, pend_d, pend_set, pend_clr;
  logic [NCAUSE-1:0] req;
  logic              sel_hit, entry, tmr_exp, priv_trap;
  logic [CW-1:0]     sel_idx;
  logic [ADDR_W-1:0] vec_addr;

  priv_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load_i),
    .val_i    (tmr_val_i),
    .user_i   (mode_q),
    .cnt_o    (tmr_count_o),
    .expire_o (tmr_exp)
  );

  assign priv_trap = priv_op_i & (mode_q == MODE_USER);
  assign req       = {pend_q & {NEXT{ie_q}}, priv_trap, trap_i};

  priv_cause_sel #(.NREQ(NCAUSE), .CW(CW)) u_sel (
    .req_i (req),
    .hit_o (sel_hit),
    .idx_o (sel_idx)
  );

  assign entry    = boundary_i & ~eret_i & sel_hit;
  assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(sel_idx) * ADDR_W'(VEC_STRIDE);

  // pending external requests: bit 0 fault, bit 1 timer, bit 2 I/O
  assign pend_set = {io_irq_i, tmr_exp, hw_fault_i};

  always_comb begin
    pend_clr = '0;
    for (int k = 0; k < NEXT; k++) begin
      if (entry && sel_idx == CW'(EXT_LO + k)) pend_clr[k] = 1'b1;
    end
    pend_d = (pend_q & ~pend_clr) | pend_set;
  end

  always_comb begin
    mode_d  = mode_q;
    prev_d  = prev_q;
    ie_d    = ie_q;
    epc_d   = epc_q;
    cause_d = cause_q;
    if (eret_i) begin
      mode_d = prev_q;
      ie_d   = 1'b1;
    end else if (entry) begin
      prev_d  = mode_q;
      mode_d  = MODE_KERNEL;
      ie_d    = 1'b0;
      epc_d   = cur_pc_i;
      cause_d = sel_idx;
    end else if (set_user_i) begin
      mode_d = MODE_USER;
      ie_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_KERNEL;
      prev_q  <= MODE_KERNEL;
      ie_q    <= 1'b0;
      epc_q   <= '0;
      cause_q <= '0;
      pend_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      prev_q  <= prev_d;
      ie_q    <= ie_d;
      epc_q   <= epc_d;
      cause_q <= cause_d;
      pend_q  <= pend_d;
    end
  end

  assign pc_load_o = entry | eret_i;
  assign pc_next_o = eret_i ? epc_q : vec_addr;
  assign epc_o     = epc_q;
  assign cause_o   = cause_q;
  assign mode_o    = mode_q;
  assign ie_o      = ie_q;

  // R3: entry lands in kernel mode with interrupts off
  a_r3_entry_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (mode_o == MODE_KERNEL && !ie_o));
  // R3: kernel mode is reached only by entry or by a return
  a_r3_no_soft_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o) |-> ($past(entry) || $past(eret_i)));
  // R2: the return address is captured from the boundary cycle
  a_r2_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (epc_o == $past(cur_pc_i)));
  // R8: a return enables interrupts
  a_r8_eret_ie: assert property (@(posedge clk) disable iff (!rst_n)
    eret_i |=> ie_o);
  // R6: with interrupts off only synchronous causes are taken
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !ie_q) |-> (sel_idx < CW'(EXT_LO)));
  // R7: pending requests survive until taken
  a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
    !entry |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R10: no program counter redirect without a boundary or return
  a_r10_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary_i && !eret_i) |-> !pc_load_o);
endmodule

// File: tb/priv_trap_ctrl_tb_top.sv
module priv_trap_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary, priv_op, io_irq, hw_fault, set_user, eret, tmr_load;
  logic [15:0] cur_pc;
  logic [4:0]  trap;
  logic [7:0]  tmr_val;
  logic        pc_load, mode, ie;
  logic [15:0] pc_next, epc;
  logic [3:0]  cause;
  logic [7:0]  tmr_count;

  int          total = 0;
  int          bad   = 0;
  logic [15:0] last_epc = 16'h0;

  always #2 clk = ~clk;

  priv_trap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .cur_pc_i(cur_pc),
    .trap_i(trap), .priv_op_i(priv_op), .io_irq_i(io_irq), .hw_fault_i(hw_fault),
    .set_user_i(set_user), .eret_i(eret), .tmr_load_i(tmr_load), .tmr_val_i(tmr_val),
    .pc_load_o(pc_load), .pc_next_o(pc_next), .epc_o(epc), .cause_o(cause),
    .mode_o(mode), .ie_o(ie), .tmr_count_o(tmr_count)
  );

  function automatic logic [15:0] vec(input int c);
    return 16'(256 + c * 4);
  endfunction

  function automatic int lowest(input logic [4:0] m);
    for (int i = 4; i >= 0; i--) if (m[i]) lowest = i;
    if (m == 5'd0) lowest = -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in;
    boundary = 0; priv_op = 0; io_irq = 0; hw_fault = 0; set_user = 0;
    eret = 0; tmr_load = 0; trap = '0; tmr_val = '0; cur_pc = '0;
  endtask

  // boundary with an event expected to enter (R2, R3)
  task automatic enter(input logic [4:0] t, input logic pv, input logic [15:0] pc, input int expc);
    @(negedge clk);
    trap = t; priv_op = pv; boundary = 1; cur_pc = pc;
    #1;
    chk("R2 pc_load", pc_load, 1);
    chk("R2 vector", pc_next, vec(expc));
    @(negedge clk);
    clear_in;
    chk("R3 mode kernel", mode, 0);
    chk("R3 ie off", ie, 0);
    chk("R2 epc", epc, pc);
    chk("R2 cause", cause, expc);
    last_epc = pc;
  endtask

  task automatic leave(input logic exp_mode);
    @(negedge clk);
    eret = 1;
    #1;
    chk("R8 pc_load", pc_load, 1);
    chk("R8 return addr", pc_next, last_epc);
    @(negedge clk);
    clear_in;
    chk("R8 mode restored", mode, exp_mode);
    chk("R8 ie on", ie, 1);
  endtask

  task automatic no_entry(input logic [4:0] t, input logic pv, input string tag);
    @(negedge clk);
    trap = t; priv_op = pv; boundary = 1; cur_pc = 16'h7770;
    #1;
    chk(tag, pc_load, 0);
    @(negedge clk);
    clear_in;
  endtask

  task automatic go_user;
    @(negedge clk);
    set_user = 1;
    @(negedge clk);
    clear_in;
    chk("R3 set_user mode", mode, 1);
    chk("R3 set_user ie", ie, 1);
  endtask

  task automatic pulse(input logic f, input logic io);
    @(negedge clk);
    hw_fault = f; io_irq = io;
    @(negedge clk);
    clear_in;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_in;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 ie", ie, 0);
    chk("R1 timer", tmr_count, 0);
    chk("R1 pc_load", pc_load, 0);
    chk("R1 cause", cause, 0);
    chk("R1 epc", epc, 0);

    // R7/R6: I/O pulse with interrupts off is not taken
    pulse(0, 1);
    no_entry(5'd0, 0, "R6 masked io");

    // R4: explicit trap taken with ie off, from kernel
    enter(5'b10000, 0, 16'h0040, 4);
    leave(0);
    // R7: the held I/O request is now taken
    enter(5'd0, 0, 16'h0044, 8);
    leave(0);

    // R10: causes without a boundary
    @(negedge clk);
    trap = 5'b00001; priv_op = 1;
    #1 chk("R10 no boundary", pc_load, 0);
    @(negedge clk);
    clear_in;
    chk("R10 mode unchanged", mode, 0);

    // R4/R5 sweep of all trap masks with and without privileged op, in user mode
    for (int m = 0; m < 32; m++) begin
      for (int pv = 0; pv < 2; pv++) begin
        go_user;
        if (m == 0 && pv == 0) begin
          no_entry(5'd0, 0, "R5 idle user");
        end else begin
          enter(5'(m), 1'(pv), 16'(16'h2000 + m * 4 + pv * 2),
                (m != 0) ? lowest(5'(m)) : 5);
          leave(1);
        end
      end
    end

    // R5: privileged op in kernel raises nothing
    enter(5'b10000, 0, 16'h0300, 4);
    no_entry(5'd0, 1, "R5 kernel priv");

    // R9: timer load in kernel, count down; I/O pulse alongside
    @(negedge clk);
    tmr_load = 1; tmr_val = 8'd3; io_irq = 1;
    @(negedge clk);
    clear_in;
    chk("R9 loaded", tmr_count, 3);
    @(negedge clk) chk("R9 count", tmr_count, 2);
    @(negedge clk) chk("R9 count", tmr_count, 1);
    @(negedge clk) chk("R9 count", tmr_count, 0);
    @(negedge clk) chk("R9 stop", tmr_count, 0);
    leave(1);
    // R6: timer beats I/O
    enter(5'd0, 0, 16'h0400, 7);
    leave(1);
    enter(5'd0, 0, 16'h0404, 8);
    leave(1);

    // R6: sync over fault over I/O
    pulse(1, 1);
    enter(5'b00010, 0, 16'h0500, 1);
    leave(1);
    enter(5'd0, 0, 16'h0504, 6);
    leave(1);
    enter(5'd0, 0, 16'h0508, 8);
    leave(1);

    // R8: return overrides a same-cycle boundary
    @(negedge clk);
    eret = 1; boundary = 1; trap = 5'b00001; cur_pc = 16'h0600;
    #1;
    chk("R8 eret wins", pc_next, last_epc);
    @(negedge clk);
    clear_in;
    chk("R8 eret mode", mode, 1);
    chk("R8 epc kept", epc, last_epc);

    // R9: user-mode load ignored
    @(negedge clk);
    tmr_load = 1; tmr_val = 8'd9;
    @(negedge clk);
    clear_in;
    chk("R9 user load", tmr_count, 0);

    // R9: loading zero in kernel raises nothing
    enter(5'b10000, 0, 16'h0700, 4);
    @(negedge clk);
    tmr_load = 1; tmr_val = 8'd0;
    @(negedge clk);
    clear_in;
    chk("R9 zero load", tmr_count, 0);
    leave(1);
    no_entry(5'd0, 0, "R9 zero load no irq");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule